// File: doc/BRIEF.md
# Selectable Page Replacement Controller

This block keeps track of which page numbers currently occupy a small, fully associative set of frames in a fast primary store. The pages themselves come from a much larger secondary store. On every reference it decides at once whether the page is resident (a hit) or missing (a fault). When a fault arrives and no frame is free, it names the frame to give up. The policy that picks this frame can be switched at run time between first-in-first-out, least recently used and most recently used. All three policies share one frame array, so they can be compared on the same stream of references.

Each frame carries a dirty flag, which is set when its page is written. When a dirty page is chosen for eviction, the block raises a write-back request together with the evicted page number. The surrounding fault handler moves the data. The hit, fault, eviction, victim and write-back outputs are combinational. They are valid in the same cycle as the reference strobe. The frame state is updated at the clock edge that ends that cycle.

Top module: `page_replacer`

## Requirements
- R1: While `ref_valid` is high, exactly one of `hit` and `fault` is high. `hit` is high when some valid frame holds `ref_page`. While `ref_valid` is low, `hit`, `fault`, `evict` and `wb_req` are all low.
- R2: On a fault while some frame is empty, `victim` is the lowest-numbered empty frame, and `evict` and `wb_req` stay low. On a hit, `victim` is the index of the frame holding the page.
- R3: With `policy` = 0 (first-in-first-out), a fault with all frames full evicts the frame whose page was loaded earliest. Later hits on that page do not change the choice.
- R4: With `policy` = 1 (least recently used), a fault with all frames full evicts the frame whose last reference is oldest. Loading a page counts as a reference.
- R5: With `policy` = 2 (most recently used), a fault with all frames full evicts the frame referenced most recently.
- R6: A write hit sets the frame's dirty flag. A write fault loads the page dirty, and a read fault loads it clean. On an eviction, `evict_page` is the page leaving the frame, and `wb_req` is high exactly when that frame is dirty.
- R7: Reset empties every frame and clears every dirty flag. The first reference after reset faults into frame 0 with no write-back.
- R8: `policy` = 3 selects the same victim as least recently used. The policy may change between references.
- R9: With 4 frames and the cycle 0,1,2,3,4 repeated three times, least recently used faults on all 15 references. Most recently used faults 7 times, at references 1 to 5, 9 and 13.
- R10: A page loaded by a fault hits when it is referenced in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_page | input | PAGE_W | Page number referenced |
| ref_write | input | 1 | The reference writes the page |
| policy | input | 2 | 0 FIFO, 1 LRU, 2 MRU, 3 LRU |
| hit | output | 1 | Page is resident |
| fault | output | 1 | Page is not resident |
| evict | output | 1 | Fault with all frames full; a page is displaced |
| victim | output | $clog2(N_FRAMES) | Frame hit, filled or replaced |
| evict_page | output | PAGE_W | Page displaced (zero when `evict` is low) |
| wb_req | output | 1 | Displaced page is dirty and must be written back |

## Verification
An eviction decision and a dirty-flag update can land on the same frame in one stream. A page can be written on a hit, then become the oldest or most recent entry, and be displaced by the next fault. Random streams over eight pages with a mix of writes provoke this constantly. For every reference, a bench model built on reference timestamps predicts the frame index, the displaced page and whether a write-back is due. The directed cyclic string then checks the fault totals and the positions of the faults for two policies.

// File: rtl/page_replacer.sv
module page_replacer #(
  parameter int N_FRAMES = 4,
  parameter int PAGE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_valid,
  input  logic [PAGE_W-1:0] ref_page,
  input  logic              ref_write,
  input  logic [1:0]        policy,
  output logic              hit,
  output logic              fault,
  output logic              evict,
  output logic [(N_FRAMES>1 ? $clog2(N_FRAMES) : 1)-1:0] victim,
  output logic [PAGE_W-1:0] evict_page,
  output logic              wb_req
);
  localparam int IW = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1;
  localparam logic [IW-1:0] OLDEST = IW'(N_FRAMES - 1);

  logic [N_FRAMES-1:0] vld, dty, match;
  logic [PAGE_W-1:0]   pg   [N_FRAMES];
  logic [IW-1:0]       age  [N_FRAMES];
  logic [IW-1:0]       lord [N_FRAMES];
  logic [IW-1:0]       hit_idx, free_idx, pick_idx;
  logic                any_free, any_match;

  for (genvar i = 0; i < N_FRAMES; i++) begin : g_cmp
    assign match[i] = vld[i] && (pg[i] == ref_page);
  end

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    pick_idx = '0;
    any_free = 1'b0;
    for (int i = 0; i < N_FRAMES; i++)
      if (match[i]) hit_idx = IW'(i);
    for (int i = N_FRAMES - 1; i >= 0; i--)
      if (!vld[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    for (int i = 0; i < N_FRAMES; i++)
      case (policy)
        2'd0:    if (lord[i] == OLDEST) pick_idx = IW'(i);
        2'd2:    if (age[i] == '0)      pick_idx = IW'(i);
        default: if (age[i] == OLDEST)  pick_idx = IW'(i);
      endcase
  end

  assign any_match  = |match;
  assign hit        = ref_valid && any_match;
  assign fault      = ref_valid && !any_match;
  assign evict      = fault && !any_free;
  assign victim     = any_match ? hit_idx : (any_free ? free_idx : pick_idx);
  assign evict_page = evict ? pg[victim] : '0;
  assign wb_req     = evict && dty[victim];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      dty <= '0;
      for (int i = 0; i < N_FRAMES; i++) begin
        pg[i]   <= '0;
        age[i]  <= '0;
        lord[i] <= '0;
      end
    end else if (ref_valid) begin
      for (int i = 0; i < N_FRAMES; i++)
        if (vld[i] && IW'(i) != victim && (!vld[victim] || age[i] < age[victim]))
          age[i] <= age[i] + 1'b1;
      age[victim] <= '0;
      if (fault) begin
        for (int i = 0; i < N_FRAMES; i++)
          if (vld[i] && IW'(i) != victim && (!vld[victim] || lord[i] < lord[victim]))
            lord[i] <= lord[i] + 1'b1;
        lord[victim] <= '0;
        pg[victim]   <= ref_page;
        vld[victim]  <= 1'b1;
        dty[victim]  <= ref_write;
      end else if (ref_write) begin
        dty[victim] <= 1'b1;
      end
    end
  end

  a_r1_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid |-> (hit ^ fault));
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_valid |-> !(hit || fault || evict || wb_req));
  a_r2_hit_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !(evict || wb_req));
  a_r6_wb_needs_evict: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (evict && fault));
  a_r10_loaded_hits: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> ((ref_valid && ref_page == $past(ref_page)) |-> hit));
endmodule

// File: tb/page_replacer_bench.sv
module page_replacer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4;
  localparam int PW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_valid = 1'b0, ref_write = 1'b0;
  logic [PW-1:0] ref_page = '0;
  logic [1:0] policy = 2'd0;
  logic hit, fault, evict, wb_req;
  logic [1:0] victim;
  logic [PW-1:0] evict_page;

  int errors = 0, checks = 0, tnow = 0;
  int m_pg [NF];
  bit m_v [NF];
  bit m_d [NF];
  int m_use [NF];
  int m_load [NF];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_replacer #(.N_FRAMES(NF), .PAGE_W(PW)) u_page_replacer (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_page(ref_page),
    .ref_write(ref_write), .policy(policy), .hit(hit), .fault(fault),
    .evict(evict), .victim(victim), .evict_page(evict_page), .wb_req(wb_req));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int find_hit(input int p);
    for (int i = 0; i < NF; i++) if (m_v[i] && m_pg[i] == p) return i;
    return -1;
  endfunction

  function automatic int find_free();
    for (int i = 0; i < NF; i++) if (!m_v[i]) return i;
    return -1;
  endfunction

  function automatic int pick(input int pol);
    int best = 0;
    for (int i = 1; i < NF; i++) begin
      if (pol == 0 && m_load[i] < m_load[best]) best = i;
      if (pol == 2 && m_use[i] > m_use[best]) best = i;
      if ((pol == 1 || pol == 3) && m_use[i] < m_use[best]) best = i;
    end
    return best;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    ref_valid = 1'b0;
    rst_n = 1'b0;
    for (int i = 0; i < NF; i++) begin m_v[i] = 0; m_d[i] = 0; end
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_ref(input int p, input bit wr, input string tag, output bit was_fault);
    int h, f, ev, e_vic;
    bit e_evict, e_wb;
    int e_pg;
    h = find_hit(p);
    f = find_free();
    e_evict = 0; e_wb = 0; e_pg = 0;
    if (h >= 0) e_vic = h;
    else if (f >= 0) e_vic = f;
    else begin
      ev = pick(int'(policy));
      e_vic = ev; e_evict = 1; e_pg = m_pg[ev]; e_wb = m_d[ev];
    end
    @(negedge clk);
    ref_valid = 1'b1; ref_page = PW'(p); ref_write = wr;
    #1;
    check(hit == (h >= 0) && fault == (h < 0), {tag, " R1 hit/fault"}, int'(hit), int'(h >= 0));
    check(int'(victim) == e_vic, {tag, " victim"}, int'(victim), e_vic);
    check(evict == e_evict && wb_req == e_wb && (!e_evict || int'(evict_page) == e_pg),
          {tag, " R6 evict/wb/page"}, int'(evict_page), e_pg);
    was_fault = fault;
    tnow++;
    m_use[e_vic] = tnow;
    if (h < 0) begin
      m_v[e_vic] = 1; m_pg[e_vic] = p; m_d[e_vic] = wr; m_load[e_vic] = tnow;
    end else if (wr) m_d[e_vic] = 1;
    @(negedge clk);
    ref_valid = 1'b0;
  endtask

  task automatic cyclic(input logic [1:0] pol, input int exp_faults, input int exp_mask, input string tag);
    int nf = 0, mask = 0;
    bit fl;
    do_reset();
    policy = pol;
    for (int k = 0; k < 15; k++) begin
      do_ref(k % 5, 1'b0, tag, fl);
      if (fl) begin nf++; mask |= (1 << k); end
    end
    check(nf == exp_faults, {tag, " R9 fault count"}, nf, exp_faults);
    check(mask == exp_mask, {tag, " R9 fault positions"}, mask, exp_mask);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit fl;
    void'($urandom(32'd4242));
    do_reset();
    #1;
    check(!hit && !fault && !evict && !wb_req, "R1 idle after reset", int'(hit | fault), 0);
    do_ref(9, 1'b0, "R7 first ref", fl);
    check(fl, "R7 first ref faults", int'(fl), 1);
    do_ref(9, 1'b0, "R10 reload hits", fl);
    do_ref(5, 1'b1, "R2 fill 1", fl);
    do_ref(6, 1'b0, "R2 fill 2", fl);
    do_ref(7, 1'b0, "R2 fill 3", fl);
    policy = 2'd0;
    do_ref(9, 1'b0, "R3 hit oldest", fl);
    do_ref(8, 1'b0, "R3 fifo evicts 9", fl);
    do_ref(1, 1'b0, "R6 fifo dirty victim 5", fl);
    policy = 2'd1;
    do_ref(6, 1'b1, "R4 touch", fl);
    do_ref(2, 1'b0, "R4 lru evict", fl);
    policy = 2'd3;
    do_ref(3, 1'b0, "R8 code3 as lru", fl);
    policy = 2'd2;
    do_ref(4, 1'b0, "R5 mru evict", fl);
    do_reset();
    do_ref(6, 1'b0, "R7 after reset", fl);
    check(fl, "R7 state cleared", int'(fl), 1);
    cyclic(2'd1, 15, 16'h7fff, "LRU cyclic R4");
    cyclic(2'd2, 7, 32'h111f, "MRU cyclic R5");
    do_reset();
    for (int k = 0; k < 600; k++) begin
      if (k % 25 == 0) policy = 2'($urandom_range(0, 3));
      do_ref(int'($urandom_range(0, 7)), 1'($urandom_range(0, 2) == 0), "random R3 R4 R5 R8", fl);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule